// File: doc/BRIEF.md
# Bus Serial Line Unit

The serial line unit connects an asynchronous character line to a 16-bit processor I/O page. It presents four word registers to the bus: receiver status, receiver data, transmitter status and transmitter data. The unit answers only inside the top 8 KB of the address space, at a base set by configuration pins. It sends and receives characters of seven or eight data bits, with one start bit, one stop bit and an optional parity bit. It raises separate receive and transmit interrupt requests and drives the matching vectors.

Strap inputs select the bit rate of each direction, the frame format, transmit break, halt on a received break, and whether error flags are visible. A console instance uses base octal 177560, with `cfg_base` = 10'h3EE, and vector bits 3 to 8 equal to 6. This places its receive and transmit vectors at octal 060 and 064.

Top module: `serial_line_unit`

## Requirements
- R1: `bus_sel` is high exactly when `bus_addr[15:13]` is 3'b111 and `bus_addr[12:3]` equals `cfg_base`. `bus_addr[2:1]` selects the register: 0 receiver status, 1 receiver data, 2 transmitter status, 3 transmitter data. `bus_rdata` is zero whenever no register is being read, and a read of the transmitter data register also returns zero.
- R2: After reset the receiver done flag (receiver status bit 7) is 0 and transmitter ready (transmitter status bit 7) is 1. Both interrupt enables are 0, `txd` idles high, and `rx_irq`, `tx_irq` and `halt_req` are low.
- R3: `rx_vector` is `{cfg_vec, 3'b000}` and `tx_vector` is `{cfg_vec, 3'b100}`. With `cfg_vec` = 6 these are octal 060 and 064.
- R4: A bit lasts UNIT*(16 - code) clock cycles. When `cfg_split` is 0, `cfg_rx_code` sets the rate of both directions. When `cfg_split` is 1, the transmitter uses `cfg_tx_code`.
- R5: A write to the transmitter data register while ready is 1 starts a frame and clears ready. The frame is sent least significant bit first: a low start bit, 7 data bits or 8 when `cfg_eight` is 1, then a parity bit if `cfg_par_en` is 1, then a high stop bit. Even parity applies unless `cfg_par_odd` is 1. Ready returns to 1 at the end of the stop bit. A write while ready is 0 is ignored.
- R6: A received character appears in bits 7:0 of the receiver data register, and the done flag is set. Reading the receiver data register clears done.
- R7: Bit 6 of each status register is a writable interrupt enable. `rx_irq` is high while receiver done and its enable are both 1. `tx_irq` is high while ready and its enable are both 1.
- R8: When `cfg_err_en` is 1, the receiver data high byte holds the error flags of the last character: bit 14 overrun (the character arrived while done was still 1), bit 13 framing (the stop bit was low), bit 12 parity, and bit 15 as the OR of the three. When `cfg_err_en` is 0, the high byte reads zero.
- R9: Transmitter status bit 0 forces `txd` low while `cfg_brk_en` is 1. While `cfg_brk_en` is 0, the bit has no effect on `txd`.
- R10: A received frame whose sampled bits are all low, stop bit included, is a break. If `cfg_halt_en` is 1, a break raises `halt_req` until the line is seen high again. If `cfg_halt_en` is 0, `halt_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Byte address on the I/O bus |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Word write strobe, one cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, zero when not selected |
| bus_sel | output | 1 | Address matches this unit |
| cfg_base | input | 10 | Base address bits 12:3 |
| cfg_vec | input | 6 | Vector bits 8:3 |
| cfg_rx_code | input | 4 | Receive rate code, also the common rate |
| cfg_tx_code | input | 4 | Transmit rate code in split mode |
| cfg_split | input | 1 | 1 selects separate rates per direction |
| cfg_eight | input | 1 | 1 selects eight data bits, 0 selects seven |
| cfg_par_en | input | 1 | Parity bit generated and checked |
| cfg_par_odd | input | 1 | Odd parity when 1 |
| cfg_brk_en | input | 1 | Allows the break control bit to act |
| cfg_halt_en | input | 1 | Received break raises halt_req |
| cfg_err_en | input | 1 | Error flags visible in the receiver data high byte |
| rxd | input | 1 | Serial input, idle high |
| txd | output | 1 | Serial output, idle high |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_vector | output | 9 | Receive vector |
| tx_vector | output | 9 | Transmit vector |
| halt_req | output | 1 | Halt request toward the processor |

## Verification
The bench drives a character at a write that lands while the transmitter is still busy. A design that accepted that write would put a second start bit on `txd` right after the first stop bit. The bench checks the rate selection in common-speed mode with a transmit code that would give a very different bit time. A unit that ignored the common-speed choice would misplace every mid-bit sample. The bench sends a second character before the first is read, a frame with a low stop bit, and a frame with the wrong parity. A design that mixed up the flag positions, kept stale flags or left them visible with flags disabled would return a wrong high byte. An all-low frame must raise `halt_req` and release it once the line goes high. A unit that ignored the enable, or re-armed on the held-low line, would halt the processor when it should not or keep it halted.

// File: rtl/slu_pkg.sv
package slu_pkg;

    typedef enum logic [1:0] {
        SLU_RX_STAT = 2'd0,
        SLU_RX_DATA = 2'd1,
        SLU_TX_STAT = 2'd2,
        SLU_TX_DATA = 2'd3
    } slu_reg_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_BITS,
        RX_WAIT
    } rx_state_e;

    typedef struct packed {
        logic eight;
        logic par_en;
        logic par_odd;
    } frame_cfg_t;

    typedef struct packed {
        logic overrun;
        logic framing;
        logic parity;
    } rx_err_t;

    // Clock cycles per bit for a 4-bit rate code.
    function automatic int bit_clocks(input logic [3:0] code, input int unit);
        return unit * (16 - int'(code));
    endfunction

    // Parity bit that completes the character (even unless odd is set).
    function automatic logic parity_of(input logic [7:0] d, input logic eight,
                                       input logic odd);
        logic [7:0] m;
        m = eight ? d : {1'b0, d[6:0]};
        return (^m) ^ odd;
    endfunction

endpackage

// File: rtl/slu_tx.sv
module slu_tx
    import slu_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period,
    input  frame_cfg_t       fmt,
    input  logic             load,
    input  logic [7:0]       data,
    input  logic             brk,
    output logic             txd,
    output logic             busy
);

    logic [10:0]      frame_q, frame_d;
    logic [3:0]       left_q, nbits;
    logic [CNT_W-1:0] tmr_q;
    logic             par;

    always_comb begin
        par        = parity_of(data, fmt.eight, fmt.par_odd);
        frame_d    = '1;
        frame_d[0] = 1'b0;
        frame_d[7:1] = data[6:0];
        if (fmt.eight) frame_d[8] = data[7];
        if (fmt.par_en) begin
            if (fmt.eight) frame_d[9] = par;
            else           frame_d[8] = par;
        end
        nbits = 4'd9 + {3'b000, fmt.eight} + {3'b000, fmt.par_en};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            frame_q <= '1;
            left_q  <= '0;
            tmr_q   <= '0;
        end else if (!busy) begin
            if (load) begin
                frame_q <= frame_d;
                left_q  <= nbits;
                tmr_q   <= period - 1'b1;
                busy    <= 1'b1;
            end
        end else if (tmr_q == '0) begin
            frame_q <= {1'b1, frame_q[10:1]};
            tmr_q   <= period - 1'b1;
            left_q  <= left_q - 1'b1;
            if (left_q == 4'd1) busy <= 1'b0;
        end else begin
            tmr_q <= tmr_q - 1'b1;
        end
    end

    assign txd = brk ? 1'b0 : (busy ? frame_q[0] : 1'b1);

    // R5
    tx_start_low_chk: assert property (@(posedge clk) disable iff (rst)
        (load && !busy && !brk) |=> (busy && !txd));

endmodule

// File: rtl/slu_rx.sv
module slu_rx
    import slu_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period,
    input  frame_cfg_t       fmt,
    input  logic             rxd,
    output logic             valid,
    output logic [7:0]       data,
    output logic             err_frame,
    output logic             err_par,
    output logic             brk
);

    logic [1:0]       sync_q;
    logic             line;
    rx_state_e        state_q;
    logic [3:0]       idx_q, par_idx, stop_idx;
    logic [CNT_W-1:0] tmr_q;
    logic [7:0]       sh_q, word;
    logic             par_q, any_one_q;

    assign line     = sync_q[1];
    assign par_idx  = 4'd8 + {3'b000, fmt.eight};
    assign stop_idx = par_idx + {3'b000, fmt.par_en};
    assign word     = fmt.eight ? sh_q : {1'b0, sh_q[7:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q    <= 2'b11;
            state_q   <= RX_IDLE;
            idx_q     <= '0;
            tmr_q     <= '0;
            sh_q      <= '0;
            par_q     <= 1'b0;
            any_one_q <= 1'b0;
            valid     <= 1'b0;
            data      <= '0;
            err_frame <= 1'b0;
            err_par   <= 1'b0;
            brk       <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], rxd};
            valid  <= 1'b0;
            case (state_q)
                RX_IDLE: if (!line) begin
                    state_q   <= RX_BITS;
                    idx_q     <= '0;
                    tmr_q     <= period >> 1;
                    any_one_q <= 1'b0;
                end
                RX_BITS: if (tmr_q != '0) begin
                    tmr_q <= tmr_q - 1'b1;
                end else begin
                    tmr_q <= period - 1'b1;
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == '0) begin
                        if (line) state_q <= RX_IDLE;
                    end else if (idx_q == stop_idx) begin
                        valid     <= 1'b1;
                        data      <= word;
                        err_frame <= !line;
                        err_par   <= fmt.par_en &&
                                     (par_q != parity_of(word, 1'b1, fmt.par_odd));
                        if (!line) begin
                            state_q <= RX_WAIT;
                            brk     <= !any_one_q;
                        end else begin
                            state_q <= RX_IDLE;
                        end
                    end else if (fmt.par_en && idx_q == par_idx) begin
                        par_q     <= line;
                        any_one_q <= any_one_q | line;
                    end else begin
                        sh_q      <= {line, sh_q[7:1]};
                        any_one_q <= any_one_q | line;
                    end
                end
                RX_WAIT: if (line) begin
                    state_q <= RX_IDLE;
                    brk     <= 1'b0;
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    // R10
    brk_release_chk: assert property (@(posedge clk) disable iff (rst)
        (brk && line) |=> !brk);

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

endmodule

// File: rtl/serial_line_unit.sv
module serial_line_unit
    import slu_pkg::*;
#(
    parameter int UNIT = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] bus_addr,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        bus_sel,
    input  logic [9:0]  cfg_base,
    input  logic [5:0]  cfg_vec,
    input  logic [3:0]  cfg_rx_code,
    input  logic [3:0]  cfg_tx_code,
    input  logic        cfg_split,
    input  logic        cfg_eight,
    input  logic        cfg_par_en,
    input  logic        cfg_par_odd,
    input  logic        cfg_brk_en,
    input  logic        cfg_halt_en,
    input  logic        cfg_err_en,
    input  logic        rxd,
    output logic        txd,
    output logic        rx_irq,
    output logic        tx_irq,
    output logic [8:0]  rx_vector,
    output logic [8:0]  tx_vector,
    output logic        halt_req
);

    localparam int CNT_W = $clog2(UNIT * 16 + 1);

    slu_reg_e         reg_sel;
    frame_cfg_t       fmt;
    logic [CNT_W-1:0] rx_period, tx_period;
    logic             rx_done, rx_ie, tx_ie, tx_brk, tx_busy, tx_ready;
    logic [7:0]       rx_buf, rx_data;
    rx_err_t          err;
    logic             rx_valid, rx_fe, rx_pe, rx_brk;
    logic             rd_rxdata, wr_txdata, wr_rxstat, wr_txstat;
    logic [7:0]       hi_byte;
    logic             unused_bits;

    assign unused_bits = ^{bus_addr[0], bus_wdata[15:8]};

    assign bus_sel   = (&bus_addr[15:13]) && (bus_addr[12:3] == cfg_base);
    assign reg_sel   = slu_reg_e'(bus_addr[2:1]);
    assign rd_rxdata = bus_rd && bus_sel && reg_sel == SLU_RX_DATA;
    assign wr_txdata = bus_wr && bus_sel && reg_sel == SLU_TX_DATA;
    assign wr_rxstat = bus_wr && bus_sel && reg_sel == SLU_RX_STAT;
    assign wr_txstat = bus_wr && bus_sel && reg_sel == SLU_TX_STAT;

    assign fmt       = '{eight: cfg_eight, par_en: cfg_par_en, par_odd: cfg_par_odd};
    assign rx_period = CNT_W'(bit_clocks(cfg_rx_code, UNIT));
    assign tx_period = CNT_W'(bit_clocks(cfg_split ? cfg_tx_code : cfg_rx_code, UNIT));

    assign tx_ready  = !tx_busy;
    assign rx_irq    = rx_done && rx_ie;
    assign tx_irq    = tx_ready && tx_ie;
    assign rx_vector = {cfg_vec, 3'b000};
    assign tx_vector = {cfg_vec, 3'b100};
    assign halt_req  = cfg_halt_en && rx_brk;

    assign hi_byte = cfg_err_en ? {(|err), err.overrun, err.framing, err.parity, 4'b0000}
                                : 8'h00;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd && bus_sel) begin
            case (reg_sel)
                SLU_RX_STAT: bus_rdata = {8'h00, rx_done, rx_ie, 6'b000000};
                SLU_RX_DATA: bus_rdata = {hi_byte, rx_buf};
                SLU_TX_STAT: bus_rdata = {8'h00, tx_ready, tx_ie, 5'b00000, tx_brk};
                default:     bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_done <= 1'b0;
            rx_ie   <= 1'b0;
            tx_ie   <= 1'b0;
            tx_brk  <= 1'b0;
            rx_buf  <= '0;
            err     <= '0;
        end else begin
            if (rx_valid) begin
                rx_done     <= 1'b1;
                rx_buf      <= rx_data;
                err.overrun <= rx_done && !rd_rxdata;
                err.framing <= rx_fe;
                err.parity  <= rx_pe;
            end else if (rd_rxdata) begin
                rx_done <= 1'b0;
            end
            if (wr_rxstat) rx_ie <= bus_wdata[6];
            if (wr_txstat) begin
                tx_ie  <= bus_wdata[6];
                tx_brk <= bus_wdata[0];
            end
        end
    end

    slu_tx #(.CNT_W(CNT_W)) i_tx (
        .clk    (clk),
        .rst    (rst),
        .period (tx_period),
        .fmt    (fmt),
        .load   (wr_txdata && tx_ready),
        .data   (bus_wdata[7:0]),
        .brk    (tx_brk && cfg_brk_en),
        .txd    (txd),
        .busy   (tx_busy)
    );

    slu_rx #(.CNT_W(CNT_W)) i_rx (
        .clk       (clk),
        .rst       (rst),
        .period    (rx_period),
        .fmt       (fmt),
        .rxd       (rxd),
        .valid     (rx_valid),
        .data      (rx_data),
        .err_frame (rx_fe),
        .err_par   (rx_pe),
        .brk       (rx_brk)
    );

    // R2
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tx_ready && !rx_done && !rx_irq && !tx_irq && !halt_req));

    // R5
    tx_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_txdata && tx_ready) |=> !tx_ready);

    // R6
    rx_set_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> rx_done);

    // R6
    rx_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_rxdata && !rx_valid) |=> !rx_done);

    // R8
    overrun_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_done && !rd_rxdata) |=> err.overrun);

endmodule

// File: tb/test_serial_line_unit.sv
module test_serial_line_unit;

    localparam int UNIT = 4;
    localparam logic [15:0] A_RXS = 16'o177560;
    localparam logic [15:0] A_RXB = 16'o177562;
    localparam logic [15:0] A_TXS = 16'o177564;
    localparam logic [15:0] A_TXB = 16'o177566;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_sel;
    logic [9:0]  cfg_base;
    logic [5:0]  cfg_vec = 6'd6;
    logic [3:0]  cfg_rx_code = 4'd13, cfg_tx_code = 4'd0;
    logic        cfg_split = 1'b0, cfg_eight = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic        cfg_brk_en = 1'b0, cfg_halt_en = 1'b0, cfg_err_en = 1'b1;
    logic        rxd = 1'b1;
    logic        txd, rx_irq, tx_irq, halt_req;
    logic [8:0]  rx_vector, tx_vector;

    int  n_tests = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;
    logic [15:0] rv;

    always #4 clk = ~clk;

    initial cfg_base = 10'(16'o177560 >> 3);

    serial_line_unit #(.UNIT(UNIT)) i_serial_line_unit (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_sel(bus_sel),
        .cfg_base(cfg_base), .cfg_vec(cfg_vec), .cfg_rx_code(cfg_rx_code),
        .cfg_tx_code(cfg_tx_code), .cfg_split(cfg_split), .cfg_eight(cfg_eight),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_brk_en(cfg_brk_en),
        .cfg_halt_en(cfg_halt_en), .cfg_err_en(cfg_err_en), .rxd(rxd), .txd(txd),
        .rx_irq(rx_irq), .tx_irq(tx_irq), .rx_vector(rx_vector), .tx_vector(tx_vector),
        .halt_req(halt_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model, every clock: address match and vectors.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            logic exp_sel;
            exp_sel = (bus_addr[15:13] == 3'b111) && (bus_addr[12:3] == cfg_base);
            chk(bus_sel === exp_sel, "R1 select", int'(bus_sel), int'(exp_sel));
            chk(rx_vector === {cfg_vec, 3'b000} && tx_vector === {cfg_vec, 3'b100},
                "R3 vectors", int'({rx_vector, tx_vector}),
                int'({cfg_vec, 3'b000, cfg_vec, 3'b100}));
        end
    end

    task automatic bus_read(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic mk_frame(input logic [7:0] d, input bit eight, input bit pen,
                            input bit odd, input bit pflip, input bit stop,
                            output logic [10:0] bits, output int n);
        int nd;
        logic p;
        nd = eight ? 8 : 7;
        p = odd;
        bits = '1;
        bits[0] = 1'b0;
        for (int i = 0; i < nd; i++) begin
            bits[1 + i] = d[i];
            p = p ^ d[i];
        end
        n = 1 + nd;
        if (pen) begin
            bits[n] = p ^ pflip;
            n++;
        end
        bits[n] = stop;
        n++;
    endtask

    // Called right after the write edge; checks every bit at its middle.
    task automatic tx_check(input logic [7:0] d, input bit eight, input bit pen,
                            input bit odd, input int p_clk, input string req);
        logic [10:0] bits;
        int n;
        mk_frame(d, eight, pen, odd, 1'b0, 1'b1, bits, n);
        repeat (p_clk / 2) @(posedge clk);
        #2;
        for (int k = 0; k < n; k++) begin
            chk(txd === bits[k], req, int'(txd), int'(bits[k]));
            if (k == 1) chk(tx_irq === 1'b0, "R5 ready low in frame", int'(tx_irq), 0);
            if (k < n - 1) begin
                repeat (p_clk) @(posedge clk);
                #2;
            end
        end
        repeat (p_clk - p_clk / 2) @(posedge clk);
        #2;
        chk(tx_irq === 1'b1, "R5 ready back after stop", int'(tx_irq), 1);
    endtask

    task automatic rx_send(input logic [7:0] d, input bit pflip, input bit stop,
                           input int p_clk);
        logic [10:0] bits;
        int n;
        mk_frame(d, cfg_eight, cfg_par_en, cfg_par_odd, pflip, stop, bits, n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rxd = bits[k];
            repeat (p_clk - 1) @(negedge clk);
        end
        @(negedge clk);
        rxd = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog all-requirements actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);

        // R2 reset state
        chk(txd === 1'b1, "R2 txd idle", int'(txd), 1);
        chk(!rx_irq && !tx_irq && !halt_req, "R2 requests low",
            int'({rx_irq, tx_irq, halt_req}), 0);
        bus_read(A_RXS, rv); chk(rv === 16'h0000, "R2 rx status", int'(rv), 0);
        bus_read(A_TXS, rv); chk(rv === 16'h0080, "R2 tx status", int'(rv), 'h80);

        // R1 decode and read data outside the unit
        bus_read(A_TXB, rv); chk(rv === 16'h0000, "R1 tx data reads zero", int'(rv), 0);
        bus_read(16'o177570, rv); chk(rv === 16'h0000, "R1 above window", int'(rv), 0);
        bus_read(16'o077564, rv); chk(rv === 16'h0000, "R1 top bits clear", int'(rv), 0);

        // R3 console vectors, then another setting
        chk(rx_vector === 9'o060 && tx_vector === 9'o064, "R3 console vectors",
            int'(rx_vector), 'o060);
        cfg_vec = 6'd9;
        @(negedge clk);
        chk(rx_vector === 9'o110 && tx_vector === 9'o114, "R3 vec 9",
            int'(tx_vector), 'o114);
        cfg_vec = 6'd6;

        // R7 transmit interrupt enable
        bus_write(A_TXS, 16'h0040);
        #2 chk(tx_irq === 1'b1, "R7 tx irq when ready", int'(tx_irq), 1);
        bus_read(A_TXS, rv); chk(rv === 16'h00C0, "R7 tx status ie", int'(rv), 'hC0);

        // R4 common speed: rx code 13 sets 12 cycles, tx code 0 ignored. R5 8-bit frame.
        bus_write(A_TXB, 16'h00A5);
        tx_check(8'hA5, 1'b1, 1'b0, 1'b0, 12, "R4 R5 common 8N1 A5");

        // R5 write while busy ignored
        bus_write(A_TXB, 16'h0055);
        repeat (5) @(posedge clk);
        bus_write(A_TXB, 16'h000F);
        repeat (125) @(posedge clk);
        #2 chk(tx_irq === 1'b1, "R5 ready after first frame", int'(tx_irq), 1);
        begin
            bit stayed_high;
            stayed_high = 1'b1;
            for (int c = 0; c < 24; c++) begin
                @(posedge clk); #2;
                if (txd !== 1'b1) stayed_high = 1'b0;
            end
            chk(stayed_high, "R5 busy write ignored", int'(stayed_high), 1);
        end

        // R4 split speed 8 cycles; R5 seven bits, odd parity
        cfg_split = 1'b1; cfg_tx_code = 4'd14; cfg_eight = 1'b0;
        cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
        bus_write(A_TXB, 16'h0041);
        tx_check(8'h41, 1'b0, 1'b1, 1'b1, 8, "R4 R5 split 7O1 41");
        cfg_par_odd = 1'b0;
        bus_write(A_TXB, 16'h0007);
        tx_check(8'h07, 1'b0, 1'b1, 1'b0, 8, "R5 7E1 07");
        cfg_eight = 1'b1; cfg_par_en = 1'b0;

        // R9 transmit break
        cfg_brk_en = 1'b1;
        bus_write(A_TXS, 16'h0041);
        #2 chk(txd === 1'b0, "R9 break drives low", int'(txd), 0);
        cfg_brk_en = 1'b0;
        #2 chk(txd === 1'b1, "R9 break disabled", int'(txd), 1);
        bus_write(A_TXS, 16'h0040);

        // R6 receive at 16 cycles per bit, R7 receive interrupt
        cfg_rx_code = 4'd12;
        bus_write(A_RXS, 16'h0040);
        #2 chk(rx_irq === 1'b0, "R7 no rx irq before char", int'(rx_irq), 0);
        rx_send(8'h5A, 1'b0, 1'b1, 16);
        chk(rx_irq === 1'b1, "R7 rx irq after char", int'(rx_irq), 1);
        bus_read(A_RXS, rv); chk(rv === 16'h00C0, "R6 done set", int'(rv), 'hC0);
        bus_read(A_RXB, rv); chk(rv === 16'h005A, "R6 data 5A", int'(rv), 'h5A);
        bus_read(A_RXS, rv); chk(rv === 16'h0040, "R6 done cleared", int'(rv), 'h40);
        chk(rx_irq === 1'b0, "R7 rx irq cleared", int'(rx_irq), 0);

        // R8 overrun
        rx_send(8'h11, 1'b0, 1'b1, 16);
        rx_send(8'h22, 1'b0, 1'b1, 16);
        bus_read(A_RXB, rv); chk(rv === 16'hC022, "R8 overrun", int'(rv), 'hC022);

        // R8 framing, flags visible then hidden
        rx_send(8'h55, 1'b0, 1'b0, 16);
        bus_read(A_RXB, rv); chk(rv === 16'hA055, "R8 framing", int'(rv), 'hA055);
        cfg_err_en = 1'b0;
        rx_send(8'h66, 1'b0, 1'b0, 16);
        bus_read(A_RXB, rv); chk(rv === 16'h0066, "R8 flags hidden", int'(rv), 'h66);
        cfg_err_en = 1'b1;

        // R8 parity error, even parity
        cfg_par_en = 1'b1;
        rx_send(8'h03, 1'b1, 1'b1, 16);
        bus_read(A_RXB, rv); chk(rv === 16'h9003, "R8 parity", int'(rv), 'h9003);
        rx_send(8'h03, 1'b0, 1'b1, 16);
        bus_read(A_RXB, rv); chk(rv === 16'h0003, "R8 clean char", int'(rv), 'h0003);
        cfg_par_en = 1'b0;

        // R10 halt on break
        cfg_halt_en = 1'b1;
        @(negedge clk) rxd = 1'b0;
        repeat (12 * 16) @(negedge clk);
        chk(halt_req === 1'b1, "R10 halt on break", int'(halt_req), 1);
        rxd = 1'b1;
        repeat (4) @(negedge clk);
        chk(halt_req === 1'b0, "R10 halt released", int'(halt_req), 0);
        bus_read(A_RXB, rv); chk(rv === 16'hA000, "R10 break char", int'(rv), 'hA000);
        cfg_halt_en = 1'b0;
        @(negedge clk) rxd = 1'b0;
        repeat (12 * 16) @(negedge clk);
        chk(halt_req === 1'b0, "R10 halt disabled", int'(halt_req), 0);
        rxd = 1'b1;
        repeat (6) @(negedge clk);
        bus_read(A_RXB, rv);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule